// File: doc/BRIEF.md
# Serial-In Latched Sink Driver

This block takes a serial bit stream and turns it into eight parallel sink-enable flags. A serial data bit is taken into an eight-stage shift chain on every rising edge of a slow shift-clock input. Bits already in the chain move one place toward the far end on the same edge. The far stage leaves the block as a serial output, so a second copy of the block can be fed from the first. A rising edge on a strobe input copies the whole chain into a holding latch in one step. The latch drives the eight outputs. Each output is a logic flag that stands in for an open-drain sink driver: 1 means sinking and 0 means off.

The shift clock, the strobe and the serial data are ordinary inputs in the system clock domain. They pass through a shared synchroniser, and rising-edge detectors turn the two control lines into one-cycle pulses. An active-low clear empties the shift chain at once, without waiting for a clock edge, and leaves the latch alone. An active-high blank input turns every output off while it is high and does not change what the latch holds.

Top module: `sink_latch_driver`

## Requirements
- R1: On each detected rising edge of `shift_clk`, the synchronised value of `ser_in` enters stage 0 of the chain.
- R2: On that same edge, every stage i (i ≥ 1) takes the old value of stage i-1. When no edge is detected, the chain holds its value.
- R3: `ser_out` always shows stage 7. A bit shifted in comes out at `ser_out` after eight shift edges in total, so a chained device receives the bits in the order they were sent.
- R4: On a detected rising edge of `strobe`, the latch takes all eight stages, with stage i going into latch bit i. When a strobe edge and a shift edge fall in the same cycle, the latch takes the chain as it was before that shift.
- R5: While `blank` is 1, all eight bits of `sink_on` are 0, whatever the latch holds.
- R6: While `blank` is 0, `sink_on[i]` equals latch bit i, and a 1 means the output is sinking. The latch changes only on a strobe edge, so a period of blank leaves it unchanged.
- R7: While `clr_n` is 0, every stage is 0, with no clock edge needed, and the latch keeps its old value. A strobe edge after the clear loads zeros into the latch.
- R8: After `rst_n` goes low, the chain, the latch and every output are 0.
- R9: A `shift_clk` or `strobe` input held high produces only one edge. Holding the level high does not shift or load again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| shift_clk | input | 1 | Shift clock level; its rising edge shifts the chain |
| strobe | input | 1 | Strobe level; its rising edge loads the latch |
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain |
| blank | input | 1 | Active-high blank that turns all outputs off |
| ser_out | output | 1 | Last stage of the chain, used for cascading |
| sink_on | output | 8 | Sink-enable flags, 1 = sinking |

## Verification
Two functions can act in the same system cycle: a strobe edge loading the latch and a shift edge moving the chain. The bench raises both inputs on the same cycle. It then expects the outputs to show the chain as it was before the shift. A second strobe then shows the shifted chain. A strobe edge that arrives while clear is low is also forced, and the outputs must read all zeros afterwards. Expected patterns come from a byte model kept in the bench. Every one of the 256 byte values is shifted in and checked.

// File: rtl/sld_pkg.sv
package sld_pkg;
    // Default chain length for the block.
    parameter int unsigned SLD_STAGES     = 8;
    // Default number of synchroniser flops.
    parameter int unsigned SLD_SYNC_DEPTH = 2;

    // Lanes in the shared input synchroniser.
    parameter int unsigned SLD_LANES      = 3;
    parameter int unsigned LANE_SHIFT     = 0;
    parameter int unsigned LANE_STROBE    = 1;
    parameter int unsigned LANE_DATA      = 2;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] flops;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.flops[0] = din;
        for (int i = 1; i < int'(DEPTH); i++) begin
            st_d.flops[i] = st_q.flops[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.flops[DEPTH-1];
endmodule

// File: rtl/sld_rise.sv
module sld_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);
    typedef struct packed {
        logic prev;
    } rise_state_t;

    rise_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = level & ~st_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);                                            // R9
    AST_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level) && level) |-> !pulse);                          // R9
endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              step,
    input  logic              bit_in,
    output logic [STAGES-1:0] stages
);
    typedef struct packed {
        logic [STAGES-1:0] cells;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.cells = {st_q.cells[STAGES-2:0], bit_in};
        end
    end

    // Reset and clear both empty the chain without waiting for a clock edge.
    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n || !clr_n) st_q <= '0;
        else                  st_q <= st_d;
    end

    assign stages = st_q.cells;

    AST_ENTRY_BIT: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        step |=> stages[0] == $past(bit_in));                          // R1
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        step |=> stages[STAGES-1:1] == $past(stages[STAGES-2:0]));     // R2
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !step |=> $stable(stages));                                    // R2
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> stages == '0);                                      // R7
endmodule

// File: rtl/sld_hold_latch.sv
module sld_hold_latch #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAGES-1:0] chain,
    input  logic              blank,
    output logic [STAGES-1:0] held,
    output logic [STAGES-1:0] sink_on
);
    typedef struct packed {
        logic [STAGES-1:0] bits;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bits = chain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held    = st_q.bits;
    assign sink_on = blank ? '0 : st_q.bits;

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> held == $past(chain));                                // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));                                      // R6
endmodule

// File: rtl/sink_latch_driver.sv
module sink_latch_driver
    import sld_pkg::*;
#(
    parameter int unsigned STAGES     = SLD_STAGES,
    parameter int unsigned SYNC_DEPTH = SLD_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              shift_clk,
    input  logic              strobe,
    input  logic              clr_n,
    input  logic              blank,
    output logic              ser_out,
    output logic [STAGES-1:0] sink_on
);
    localparam int unsigned LAST = STAGES - 1;

    logic [SLD_LANES-1:0] raw_lanes, sync_lanes;
    logic [1:0]           edge_pulse;
    logic [STAGES-1:0]    chain;
    logic [STAGES-1:0]    held;

    assign raw_lanes[LANE_SHIFT]  = shift_clk;
    assign raw_lanes[LANE_STROBE] = strobe;
    assign raw_lanes[LANE_DATA]   = ser_in;

    sld_sync #(.WIDTH(SLD_LANES), .DEPTH(SYNC_DEPTH)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lanes),
        .dout  (sync_lanes)
    );

    // One edge detector for each of the two control lanes.
    for (genvar g = 0; g < 2; g++) begin : g_edge
        sld_rise i_rise (
            .clk   (clk),
            .rst_n (rst_n),
            .level (sync_lanes[g]),
            .pulse (edge_pulse[g])
        );
    end

    sld_shift_chain #(.STAGES(STAGES)) i_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .step   (edge_pulse[LANE_SHIFT]),
        .bit_in (sync_lanes[LANE_DATA]),
        .stages (chain)
    );

    sld_hold_latch #(.STAGES(STAGES)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (edge_pulse[LANE_STROBE]),
        .chain   (chain),
        .blank   (blank),
        .held    (held),
        .sink_on (sink_on)
    );

    assign ser_out = chain[LAST];

    AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> sink_on == '0);                                      // R5
    AST_UNBLANK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> sink_on == held);                                   // R6
    AST_SEROUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !edge_pulse[LANE_SHIFT] |=> $stable(ser_out));                 // R3
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (edge_pulse[LANE_SHIFT] && edge_pulse[LANE_STROBE]) |=> held == $past(chain)); // R4
endmodule

// File: tb/test_sink_latch_driver.sv
module test_sink_latch_driver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       shift_clk = 1'b0;
    logic       strobe = 1'b0;
    logic       clr_n = 1'b1;
    logic       blank = 1'b0;
    logic       ser_out;
    logic [7:0] sink_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_reg = '0;
    logic [7:0] exp_latch = '0;

    always #2.5 clk = ~clk;

    sink_latch_driver i_sink_latch_driver (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .strobe(strobe), .clr_n(clr_n), .blank(blank),
        .ser_out(ser_out), .sink_on(sink_on)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive the two edge inputs high together (either can be omitted), then low.
    task automatic pulse(input bit do_shift, input bit do_strobe, input bit b, input int high_len);
        @(negedge clk);
        ser_in = b;
        if (do_shift)  shift_clk = 1'b1;
        if (do_strobe) strobe = 1'b1;
        wait_n(high_len);
        shift_clk = 1'b0;
        strobe = 1'b0;
        wait_n(4);
        if (do_strobe) exp_latch = exp_reg;
        if (do_shift)  exp_reg = {exp_reg[6:0], b};
    endtask

    task automatic load_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) pulse(1'b1, 1'b0, v[k], 4);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        chk("R8 reset outputs", sink_on, 8'h00);
        chk("R8 reset ser_out", {7'b0, ser_out}, 8'h00);

        // Sweep every byte: shift it in, strobe it, compare outputs and cascade bit.
        for (int v = 0; v < 256; v++) begin
            load_byte(8'(v));
            chk("R3 ser_out first bit", {7'b0, ser_out}, {7'b0, exp_reg[7]});
            pulse(1'b0, 1'b1, 1'b0, 4);
            chk("R1 R2 R4 R6 sink pattern", sink_on, exp_latch);
        end

        // R5: blank forces all outputs off; R6: latch is intact afterwards.
        load_byte(8'hA5);
        pulse(1'b0, 1'b1, 1'b0, 4);
        @(negedge clk); blank = 1'b1;
        @(negedge clk);
        chk("R5 blank off", sink_on, 8'h00);
        load_byte(8'h3C);
        pulse(1'b0, 1'b1, 1'b0, 4);
        chk("R5 blank while strobed", sink_on, 8'h00);
        @(negedge clk); blank = 1'b0;
        @(negedge clk);
        chk("R6 unblank shows latch", sink_on, 8'h3C);

        // R4 same cycle: strobe and shift together load the pre-shift chain.
        pulse(1'b1, 1'b1, 1'b1, 4);
        chk("R4 same cycle old chain", sink_on, 8'h3C);
        pulse(1'b0, 1'b1, 1'b0, 4);
        chk("R4 same cycle later strobe", sink_on, 8'h79);

        // R9: shift_clk held high for many cycles shifts only once.
        load_byte(8'h00);
        pulse(1'b1, 1'b0, 1'b1, 30);
        pulse(1'b0, 1'b1, 1'b0, 30);
        chk("R9 held level single edge", sink_on, 8'h01);

        // R7: clear empties the chain at once and leaves the latch alone.
        load_byte(8'hFF);
        #1 clr_n = 1'b0;
        #1;
        chk("R7 clear ser_out immediate", {7'b0, ser_out}, 8'h00);
        chk("R7 clear keeps latch", sink_on, 8'h01);
        exp_reg = 8'h00;
        pulse(1'b0, 1'b1, 1'b0, 4);
        chk("R7 strobe during clear loads zeros", sink_on, 8'h00);
        @(negedge clk); clr_n = 1'b1;
        pulse(1'b1, 1'b0, 1'b1, 4);
        pulse(1'b0, 1'b1, 1'b0, 4);
        chk("R7 shifting after clear", sink_on, 8'h01);

        // R8: reset mid-run empties chain and latch.
        load_byte(8'hC3);
        pulse(1'b0, 1'b1, 1'b0, 4);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears outputs", sink_on, 8'h00);
        chk("R8 reset clears ser_out", {7'b0, ser_out}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule